// File: doc/BRIEF.md
# Track Index and Sector Mark Generator

This block produces the index mark and the sector marks of a rotating-disk track. It is driven by a byte tick that is locked to the spindle. A track is `TRACK_BYTES` byte times long (24000 by default) and is divided into N sectors. The first sector opens with the index pulse. Every later sector opens with a sector pulse. A current-sector number is also output so that a controller can tell where the head is.

N can come from two places. One is a 2-bit switch setting. The other is a count loaded by a set-sector command, and that count overrides the switches until a power-up revert strobe hands control back to them. For each N the block works out the common sector length floor(T/N) and the longer final sector that takes up the remainder. It does this by repeated subtraction over several cycles, and a busy flag is high while that runs. A new N is adopted only at the next track start, so the revolution in progress always finishes with the count it began with.

Top module: `sector_mark_gen`

## Requirements
- R1: With N active and T = TRACK_BYTES, sectors 0 to N-2 each last floor(T/N) byte ticks and sector N-1 lasts T-(N-1)*floor(T/N) ticks, so one track is exactly T ticks long.
- R2: `index_pulse` is high for the first IDX_TICKS ticks of sector 0 and at no other time. Sector 0 never produces a sector pulse.
- R3: Each of sectors 1 to N-1 raises `sector_pulse` for its first SEC_TICKS ticks.
- R4: `sector_num` steps through 0, 1, ..., N-1 in order and then returns to 0 at the track boundary.
- R5: With no programmed count active, `sw_sel` = 2'b00, 2'b01, 2'b10 and 2'b11 select N = 111, 69, 40 and 21 respectively.
- R6: A `set_load` strobe carrying a `set_count` in 3..255 makes that value N. While a programmed count is active, changes to `sw_sel` have no effect and start no recomputation.
- R7: A `set_load` with `set_count` of 0, 1 or 2 is rejected. N stays unchanged, `bad_count` goes high on the cycle after the strobe, and the next accepted load clears it.
- R8: A `pwr_revert` strobe drops any programmed count and returns to the switch setting.
- R9: A change of N first affects the track that starts at the next index. The revolution in progress completes with its old N.
- R10: `calc_busy` is high while a sector length is being computed. After reset, all marks stay low until the first computation ends, and the first index then begins at once.
- R11: Sector position and `sector_num` advance only on cycles where `byte_tick` is high. Between ticks they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_tick | input | 1 | One-cycle strobe per byte time |
| sw_sel | input | 2 | Switch setting for the sector count |
| set_load | input | 1 | Set-sector command strobe |
| set_count | input | 8 | Requested sector count |
| pwr_revert | input | 1 | Power-up strobe that restores the switch count |
| index_pulse | output | 1 | Track-start mark |
| sector_pulse | output | 1 | Sector-start mark for sectors 1..N-1 |
| sector_num | output | 8 | Current sector number |
| calc_busy | output | 1 | Sector length computation in progress |
| bad_count | output | 1 | Last set-sector count was rejected |

## Verification
The marks and `sector_num` come straight from state that is updated on the tick edge. They therefore change on the clock edge that samples a tick, and the bench reads them at the falling edge that follows. Sector lengths are counted in ticks rather than clock cycles: the bench counts every tick it drives while a given sector number is visible. `bad_count` is due one edge after the strobe, and the bench checks it at the very next falling edge. `calc_busy` rises two edges after a change of target count, so the bench latches any busy it sees during a revolution and compares that with whether the target changed. A new N is due only at the next index, so the bench changes the configuration just after a track boundary and expects the new lengths one revolution later.

// File: rtl/smg_pkg.sv
package smg_pkg;
  localparam int CNT_W   = 8;
  localparam int MIN_CNT = 3;

  // switch setting to sector count
  function automatic logic [CNT_W-1:0] sw_count(input logic [1:0] sw);
    case (sw)
      2'b00:   return CNT_W'(111);
      2'b01:   return CNT_W'(69);
      2'b10:   return CNT_W'(40);
      default: return CNT_W'(21);
    endcase
  endfunction

  function automatic logic count_legal(input logic [CNT_W-1:0] c);
    return c >= CNT_W'(MIN_CNT);
  endfunction
endpackage

// File: rtl/smg_divider.sv
module smg_divider #(
  parameter int TRACK = 24000,
  parameter int NW    = 8,
  localparam int LW   = $clog2(TRACK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] n_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [NW-1:0] n_o,
  output logic [LW-1:0] q_o,
  output logic [LW-1:0] last_o
);
  logic [LW-1:0] rem_q, quo_q;
  logic [NW-1:0] div_q;
  logic          busy_q, done_q;
  logic          can_sub;

  assign can_sub = rem_q >= LW'(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= LW'(TRACK);
        quo_q  <= '0;
        div_q  <= n_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (can_sub) begin
          rem_q <= rem_q - LW'(div_q);
          quo_q <= quo_q + LW'(1);
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign n_o    = div_q;
  assign q_o    = quo_q;
  assign last_o = quo_q + rem_q;   // T-(N-1)q = q + remainder

  // R1: a finished result divides the track exactly
  p_div_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((32'(quo_q) * 32'(div_q) + 32'(rem_q)) == 32'(TRACK))
               && (rem_q < LW'(div_q)));
  // R10: busy ends with exactly one done pulse
  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/smg_cfg.sv
module smg_cfg
  import smg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             revert_i,
  input  logic [1:0]       sw_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic [CNT_W-1:0] want_o,
  output logic             illegal_o
);
  logic             prog_sel_q, illegal_q, issued_v_q;
  logic [CNT_W-1:0] prog_cnt_q, issued_q;

  always_comb begin
    want_o  = prog_sel_q ? prog_cnt_q : sw_count(sw_i);
    start_o = !busy_i && (!issued_v_q || (want_o != issued_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_sel_q <= 1'b0;
      prog_cnt_q <= '0;
      illegal_q  <= 1'b0;
      issued_v_q <= 1'b0;
      issued_q   <= '0;
    end else begin
      if (revert_i) begin
        prog_sel_q <= 1'b0;
      end else if (load_i) begin
        if (count_legal(load_cnt_i)) begin
          prog_sel_q <= 1'b1;
          prog_cnt_q <= load_cnt_i;
          illegal_q  <= 1'b0;
        end else begin
          illegal_q  <= 1'b1;
        end
      end
      if (start_o) begin
        issued_v_q <= 1'b1;
        issued_q   <= want_o;
      end
    end
  end

  assign illegal_o = illegal_q;

  // R7: a rejected count leaves the programmed state alone
  p_reject_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !revert_i && !count_legal(load_cnt_i))
      |=> illegal_o && $stable(prog_cnt_q) && $stable(prog_sel_q));
  // R8: revert always hands control back to the switches
  p_revert_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    revert_i |=> (want_o == sw_count(sw_i)));
endmodule

// File: rtl/smg_track.sv
module smg_track #(
  parameter int TRACK = 24000,
  parameter int NW    = 8,
  parameter int IDX_W = 100,
  parameter int SEC_W = 1,
  localparam int LW   = $clog2(TRACK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          res_v_i,
  input  logic [NW-1:0] res_n_i,
  input  logic [LW-1:0] res_q_i,
  input  logic [LW-1:0] res_last_i,
  output logic          index_o,
  output logic          sector_o,
  output logic [NW-1:0] sec_o
);
  logic          run_q, pend_v_q;
  logic [NW-1:0] act_n_q, pend_n_q, sec_q;
  logic [LW-1:0] act_q_q, act_last_q, pend_q_q, pend_last_q, pos_q;
  logic [LW-1:0] cur_len;
  logic          last_sec, end_of_sec, wrap_now;

  always_comb begin
    last_sec   = sec_q == (act_n_q - NW'(1));
    cur_len    = last_sec ? act_last_q : act_q_q;
    end_of_sec = run_q && tick_i && (pos_q == cur_len - LW'(1));
    wrap_now   = end_of_sec && last_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      pend_v_q    <= 1'b0;
      act_n_q     <= NW'(1);
      act_q_q     <= '0;
      act_last_q  <= '0;
      pend_n_q    <= '0;
      pend_q_q    <= '0;
      pend_last_q <= '0;
      sec_q       <= '0;
      pos_q       <= '0;
    end else begin
      if (run_q && tick_i) begin
        if (end_of_sec) begin
          pos_q <= '0;
          if (last_sec) begin
            sec_q <= '0;
            if (pend_v_q) begin
              act_n_q    <= pend_n_q;
              act_q_q    <= pend_q_q;
              act_last_q <= pend_last_q;
              pend_v_q   <= 1'b0;
            end
          end else begin
            sec_q <= sec_q + NW'(1);
          end
        end else begin
          pos_q <= pos_q + LW'(1);
        end
      end
      if (res_v_i) begin
        if (!run_q) begin
          run_q      <= 1'b1;
          act_n_q    <= res_n_i;
          act_q_q    <= res_q_i;
          act_last_q <= res_last_i;
          sec_q      <= '0;
          pos_q      <= '0;
        end else begin
          pend_v_q    <= 1'b1;
          pend_n_q    <= res_n_i;
          pend_q_q    <= res_q_i;
          pend_last_q <= res_last_i;
        end
      end
    end
  end

  assign index_o  = run_q && (sec_q == '0) && (pos_q < LW'(IDX_W));
  assign sector_o = run_q && (sec_q != '0) && (pos_q < LW'(SEC_W));
  assign sec_o    = sec_q;

  // R11: nothing moves without a byte tick
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i) |=> $stable(sec_q) && $stable(pos_q));
  // R2: the two marks never overlap
  p_one_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(index_o && sector_o));
  // R4: sector number stays inside the active count
  p_sec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (sec_q < act_n_q));
  // R9: end of the last sector leads to sector 0 with the index raised
  p_wrap_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now |=> (sec_q == '0) && index_o);
  // R10: no mark before the first result
  p_quiet_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !index_o && !sector_o);
endmodule

// File: rtl/sector_mark_gen.sv
module sector_mark_gen
  import smg_pkg::*;
#(
  parameter int TRACK_BYTES = 24000,
  parameter int IDX_TICKS   = 100,
  parameter int SEC_TICKS   = 1,
  localparam int LW         = $clog2(TRACK_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_tick,
  input  logic [1:0] sw_sel,
  input  logic       set_load,
  input  logic [7:0] set_count,
  input  logic       pwr_revert,
  output logic       index_pulse,
  output logic       sector_pulse,
  output logic [7:0] sector_num,
  output logic       calc_busy,
  output logic       bad_count
);
  logic             div_start, div_busy, div_done;
  logic [CNT_W-1:0] want_n, div_n;
  logic [LW-1:0]    div_q, div_last;

  smg_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (set_load),
    .load_cnt_i (set_count),
    .revert_i   (pwr_revert),
    .sw_i       (sw_sel),
    .busy_i     (div_busy),
    .start_o    (div_start),
    .want_o     (want_n),
    .illegal_o  (bad_count)
  );

  smg_divider #(.TRACK(TRACK_BYTES), .NW(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .n_i     (want_n),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .n_o     (div_n),
    .q_o     (div_q),
    .last_o  (div_last)
  );

  smg_track #(.TRACK(TRACK_BYTES), .NW(CNT_W), .IDX_W(IDX_TICKS),
              .SEC_W(SEC_TICKS)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (byte_tick),
    .res_v_i    (div_done),
    .res_n_i    (div_n),
    .res_q_i    (div_q),
    .res_last_i (div_last),
    .index_o    (index_pulse),
    .sector_o   (sector_pulse),
    .sec_o      (sector_num)
  );

  assign calc_busy = div_busy;

  // R10: a count change always launches a computation when idle
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> calc_busy);
endmodule

// File: tb/sector_mark_gen_test.sv
module sector_mark_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRK   = 2000;
  localparam int IDXW  = 6;
  localparam int SECW  = 2;
  localparam int NREV  = 17;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_tick = 1'b0;
  logic [1:0] sw_sel = 2'b00;
  logic       set_load = 1'b0;
  logic [7:0] set_count = 8'd0;
  logic       pwr_revert = 1'b0;
  logic       index_pulse, sector_pulse, calc_busy, bad_count;
  logic [7:0] sector_num;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_mark_gen #(.TRACK_BYTES(TRK), .IDX_TICKS(IDXW), .SEC_TICKS(SECW)) uut (
    .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .sw_sel(sw_sel),
    .set_load(set_load), .set_count(set_count), .pwr_revert(pwr_revert),
    .index_pulse(index_pulse), .sector_pulse(sector_pulse),
    .sector_num(sector_num), .calc_busy(calc_busy), .bad_count(bad_count));

  function automatic int sw_n(input logic [1:0] s);
    int tbl[4] = '{111, 69, 40, 21};
    return tbl[s];
  endfunction

  function automatic int sec_len(input int n, input int s);
    int base = TRK / n;
    if (s == n - 1) return TRK - base * (n - 1);
    return base;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench view of configuration
  int  tgt_n = 111;
  bit  prog_on = 0;
  int  prog_val = 0;
  bit  exp_busy = 0;
  bit  saw_busy = 0;
  int  ill_wait = 0;
  bit  ill_exp = 0;

  task automatic set_target(input int nt);
    exp_busy = (nt != tgt_n);
    tgt_n = nt;
  endtask

  task automatic do_load(input int v);
    set_load = 1'b1;
    set_count = 8'(v);
    ill_wait = 1;
    if (v >= 3) begin
      ill_exp = 0; prog_on = 1; prog_val = v; set_target(v);
    end else begin
      ill_exp = 1; exp_busy = 0;
    end
  endtask

  task automatic do_sw(input logic [1:0] s);
    sw_sel = s;
    if (prog_on) exp_busy = 0; else set_target(sw_n(s));
  endtask

  task automatic do_revert();
    pwr_revert = 1'b1;
    prog_on = 0;
    set_target(sw_n(sw_sel));
  endtask

  task automatic action(input int r);
    exp_busy = 0;
    case (r)
      1: do_sw(2'b01);          // R5
      2: do_sw(2'b11);          // R5
      3: do_load(3);            // R6 minimum
      4: do_load(255);          // R6 maximum
      5: do_load(2);            // R7
      6: do_sw(2'b10);          // R6 ignored while programmed
      7: do_load(0);            // R7
      8: do_revert();           // R8 -> 40
      9: do_load(100);          // R7 clear
      10: do_load(100);         // same count, no recompute
      default: begin
        if (r > 10) begin
          case ($urandom % 3)
            0: do_load(3 + int'($urandom % 253));
            1: do_sw(2'($urandom));
            default: do_revert();
          endcase
        end
      end
    endcase
  endtask

  initial begin
    int  cyc = 0;
    int  rev = 0;
    int  cur = 0;
    int  cnt = 0;
    int  exp_n = 0;
    bit  started = 0;
    bit  pulse_ok = 1;
    void'($urandom(32'd11));
    // reset state
    repeat (3) @(negedge clk);
    check("R10 reset index", int'(index_pulse), 0);
    check("R10 reset sector", int'(sector_pulse), 0);
    check("R4 reset number", int'(sector_num), 0);
    check("R10 reset busy", int'(calc_busy), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 busy after reset", int'(calc_busy), 1);
    check("R10 no index while computing", int'(index_pulse), 0);

    while (rev < NREV && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      set_load = 1'b0;
      pwr_revert = 1'b0;
      if (calc_busy) saw_busy = 1;
      if (ill_wait > 0) begin
        ill_wait--;
        if (ill_wait == 0) check("R7 bad_count", int'(bad_count), int'(ill_exp));
      end
      if (!started) begin
        if (index_pulse) begin
          started = 1; cur = 0; cnt = 0; exp_n = tgt_n; pulse_ok = 1;
          check("R4 first sector", int'(sector_num), 0);
          saw_busy = 0; exp_busy = 0;
        end else if (sector_pulse) begin
          check("R10 early sector mark", 1, 0);
        end
      end else if (int'(sector_num) != cur) begin
        check($sformatf("R1 length n=%0d s=%0d", exp_n, cur), cnt, sec_len(exp_n, cur));
        check("R2/R3 pulse shape", int'(pulse_ok), 1);
        check("R4 next number", int'(sector_num), (cur == exp_n - 1) ? 0 : cur + 1);
        if (sector_num == 8'd0) begin
          check("R9 busy only on target change", int'(saw_busy), int'(exp_busy));
          check("R10 idle at index", int'(calc_busy), 0);
          exp_n = tgt_n;
          rev++;
          saw_busy = 0;
          action(rev);
        end
        cur = int'(sector_num);
        cnt = 0;
        pulse_ok = 1;
      end
      if (started) begin
        if (index_pulse != (cur == 0 && cnt < IDXW)) pulse_ok = 0;
        if (sector_pulse != (cur != 0 && cnt < SECW)) pulse_ok = 0;
      end
      byte_tick = ($urandom % 4) != 0;   // R11 gaps between ticks
      if (started && byte_tick) cnt++;
    end
    if (cyc >= LIMIT) check("watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule